// File: doc/BRIEF.md
# Dual-Role OTG Role Tracker

This block follows the role a dual-role USB controller currently plays on the cable: the host side that sources VBUS (A-device) or the peripheral side that receives it (B-device). It samples level status inputs: the ID pin reading, VBUS valid, whether a partner is attached, and whether the bus is suspended. It also takes a latched HNP-enable flag and a set of single-cycle event strobes from software.

Wherever the next state follows from the status inputs alone, the machine moves without help. This covers bringing VBUS up, waiting for a partner, entering host or peripheral, and the VBUS timeouts. Where software must decide, the machine holds its state until the matching strobe arrives. These cases are suspending the bus, resuming, taking the host role on the B side, reclaiming the host role on the A side, and clearing a VBUS fault. The encoded state is always visible on a status output, together with a VBUS drive enable and host/peripheral mode flags.

Top module: `otg_role_fsm`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `state_code` is 0 (idle on the B side), and `vbus_drive`, `host_mode` and `periph_mode` are 0.
- R2: `state_code` always shows the state reached, with this encoding: 0 b-idle, 1 b-wait-partner, 2 b-peripheral, 3 b-host, 4 a-idle, 5 a-wait-vbus-rise, 6 a-wait-partner, 7 a-host, 8 a-suspend, 9 a-peripheral, 10 a-wait-vbus-fall, 11 a-vbus-error. No other value ever appears.
- R3: With `id_is_a` high, the path 0→4→5 is taken one state per clock with no event. State 5 then goes to 6 on the edge where `vbus_ok` is high. State 6 goes to 7 on the edge where `peer_attached` is high. A disconnect in 7 returns to 6.
- R4: If `vbus_ok` stays low, the machine leaves state 5 for state 11 after exactly `vrise_limit`+1 cycles in state 5.
- R5: If `peer_attached` stays low, the machine leaves state 6 for state 10 after exactly `bcon_limit`+1 cycles in state 6.
- R6: With `id_is_a` low, state 0 goes to 1 when `vbus_ok` is high, and state 1 goes to 2 when `peer_attached` is high. In any B-side state other than 0, loss of `vbus_ok` or a high `id_is_a` returns the machine to 0.
- R7: In state 7, `ev_bus_suspend` moves the machine to 8. In state 8, `ev_bus_resume` moves it back to 7.
- R8: In state 8, a low `peer_attached` moves the machine to 9 when `hnp_en` is high and to 6 when it is low. In state 9, `ev_reclaim` moves it to 6.
- R9: State 2 goes to 3 only on `ev_req_host` with both `hnp_en` and `bus_idle` high. In state 3, a low `peer_attached` returns the machine to 2.
- R10: In any A-side state, `id_is_a` going low sends the machine to state 10. State 10 holds while `vbus_ok` is high. When `vbus_ok` is low it goes to 0 if `id_is_a` is low, or to 4 if `id_is_a` is high.
- R11: In states 6, 7, 8 and 9, loss of `vbus_ok` goes to state 11. State 11 is left only by `ev_clear_err` (to 10) or by `id_is_a` going low (to 10).
- R12: `vbus_drive` is 1 exactly in states 5, 6, 7, 8 and 9.
- R13: `host_mode` is 1 exactly in states 3 and 7. `periph_mode` is 1 exactly in states 2 and 9.
- R14: An event strobe that does not apply to the current state, or whose conditions are not met, leaves `state_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_is_a | input | 1 | ID pin reads A-device (1) or B-device (0) |
| vbus_ok | input | 1 | VBUS is above the valid threshold |
| peer_attached | input | 1 | Remote partner is connected (0 = disconnected) |
| bus_idle | input | 1 | Bus is currently suspended |
| hnp_en | input | 1 | HNP enable flag latched by software |
| ev_bus_suspend | input | 1 | Software strobe: suspend the bus as host |
| ev_bus_resume | input | 1 | Software strobe: resume the bus as host |
| ev_req_host | input | 1 | Software strobe: B side takes the host role |
| ev_reclaim | input | 1 | Software strobe: A side takes back the host role |
| ev_clear_err | input | 1 | Software strobe: acknowledge the VBUS fault |
| vrise_limit | input | TMR_W | Cycle limit for the VBUS-rise wait |
| bcon_limit | input | TMR_W | Cycle limit for the partner-connect wait |
| state_code | output | 4 | Encoded current state |
| vbus_drive | output | 1 | Enable for the VBUS source |
| host_mode | output | 1 | Controller acts as host |
| periph_mode | output | 1 | Controller acts as peripheral |

## Verification
The bench builds the block with `TMR_W` = 8 and drives the limit ports with 3 for the VBUS-rise wait and 5 for the partner wait. Both timeout exits, and the exact number of cycles spent before them, can therefore be observed in a handful of clocks. The 8-bit counter still leaves the saturation ceiling far above these limits. The small limits also keep each directed scenario short enough to walk every automatic and software-gated transition from a fresh reset.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

    typedef enum logic [3:0] {
        ST_B_IDLE      = 4'd0,
        ST_B_WAIT_PEER = 4'd1,
        ST_B_PERIPH    = 4'd2,
        ST_B_HOST      = 4'd3,
        ST_A_IDLE      = 4'd4,
        ST_A_VRISE     = 4'd5,
        ST_A_WAIT_PEER = 4'd6,
        ST_A_HOST      = 4'd7,
        ST_A_SUSPEND   = 4'd8,
        ST_A_PERIPH    = 4'd9,
        ST_A_VFALL     = 4'd10,
        ST_A_VBUS_ERR  = 4'd11
    } otg_state_e;

    localparam int NUM_TIMED = 2;

    typedef struct packed {
        logic id_a;
        logic vbus_ok;
        logic peer;
        logic bus_idle;
        logic hnp;
    } otg_status_t;

    typedef struct packed {
        logic suspend;
        logic resume;
        logic req_host;
        logic reclaim;
        logic clear_err;
    } otg_events_t;

    typedef struct packed {
        logic vbus_drive;
        logic host;
        logic periph;
    } otg_role_t;

    function automatic logic is_a_side(otg_state_e s);
        return (s >= ST_A_IDLE);
    endfunction

    function automatic logic sources_vbus(otg_state_e s);
        return (s >= ST_A_VRISE) && (s <= ST_A_PERIPH);
    endfunction

    function automatic otg_state_e timed_state(int idx);
        return (idx == 0) ? ST_A_VRISE : ST_A_WAIT_PEER;
    endfunction

endpackage

// File: rtl/otg_wait_timer.sv
module otg_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = active && (cnt >= limit);
endmodule

// File: rtl/otg_next_state.sv
module otg_next_state
    import otg_role_pkg::*;
(
    input  otg_state_e  cur,
    input  otg_status_t st,
    input  otg_events_t ev,
    input  logic        vrise_expired,
    input  logic        bcon_expired,
    output otg_state_e  nxt
);
    always_comb begin
        nxt = cur;
        if (is_a_side(cur) && cur != ST_A_VFALL && !st.id_a) begin
            nxt = ST_A_VFALL;
        end else if (sources_vbus(cur) && cur != ST_A_VRISE && !st.vbus_ok) begin
            nxt = ST_A_VBUS_ERR;
        end else if (!is_a_side(cur) && cur != ST_B_IDLE && (st.id_a || !st.vbus_ok)) begin
            nxt = ST_B_IDLE;
        end else begin
            case (cur)
                ST_B_IDLE: begin
                    if (st.id_a)         nxt = ST_A_IDLE;
                    else if (st.vbus_ok) nxt = ST_B_WAIT_PEER;
                end
                ST_B_WAIT_PEER: begin
                    if (st.peer) nxt = ST_B_PERIPH;
                end
                ST_B_PERIPH: begin
                    if (ev.req_host && st.hnp && st.bus_idle) nxt = ST_B_HOST;
                end
                ST_B_HOST: begin
                    if (!st.peer) nxt = ST_B_PERIPH;
                end
                ST_A_IDLE: begin
                    nxt = ST_A_VRISE;
                end
                ST_A_VRISE: begin
                    if (st.vbus_ok)         nxt = ST_A_WAIT_PEER;
                    else if (vrise_expired) nxt = ST_A_VBUS_ERR;
                end
                ST_A_WAIT_PEER: begin
                    if (st.peer)           nxt = ST_A_HOST;
                    else if (bcon_expired) nxt = ST_A_VFALL;
                end
                ST_A_HOST: begin
                    if (!st.peer)         nxt = ST_A_WAIT_PEER;
                    else if (ev.suspend)  nxt = ST_A_SUSPEND;
                end
                ST_A_SUSPEND: begin
                    if (!st.peer)       nxt = st.hnp ? ST_A_PERIPH : ST_A_WAIT_PEER;
                    else if (ev.resume) nxt = ST_A_HOST;
                end
                ST_A_PERIPH: begin
                    if (ev.reclaim) nxt = ST_A_WAIT_PEER;
                end
                ST_A_VFALL: begin
                    if (!st.vbus_ok) nxt = st.id_a ? ST_A_IDLE : ST_B_IDLE;
                end
                ST_A_VBUS_ERR: begin
                    if (ev.clear_err) nxt = ST_A_VFALL;
                end
                default: nxt = ST_B_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/otg_role_decode.sv
module otg_role_decode
    import otg_role_pkg::*;
(
    input  otg_state_e cur,
    output otg_role_t  role
);
    always_comb begin
        role.vbus_drive = sources_vbus(cur);
        role.host       = (cur == ST_A_HOST) || (cur == ST_B_HOST);
        role.periph     = (cur == ST_A_PERIPH) || (cur == ST_B_PERIPH);
    end
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
    import otg_role_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_is_a,
    input  logic             vbus_ok,
    input  logic             peer_attached,
    input  logic             bus_idle,
    input  logic             hnp_en,
    input  logic             ev_bus_suspend,
    input  logic             ev_bus_resume,
    input  logic             ev_req_host,
    input  logic             ev_reclaim,
    input  logic             ev_clear_err,
    input  logic [TMR_W-1:0] vrise_limit,
    input  logic [TMR_W-1:0] bcon_limit,
    output logic [3:0]       state_code,
    output logic             vbus_drive,
    output logic             host_mode,
    output logic             periph_mode
);
    otg_state_e  state_q;
    otg_state_e  state_d;
    otg_status_t stat;
    otg_events_t evs;
    otg_role_t   role;

    logic [TMR_W-1:0] limits  [NUM_TIMED];
    logic             expired [NUM_TIMED];

    assign stat = '{id_a: id_is_a, vbus_ok: vbus_ok, peer: peer_attached,
                    bus_idle: bus_idle, hnp: hnp_en};
    assign evs  = '{suspend: ev_bus_suspend, resume: ev_bus_resume,
                    req_host: ev_req_host, reclaim: ev_reclaim,
                    clear_err: ev_clear_err};

    assign limits[0] = vrise_limit;
    assign limits[1] = bcon_limit;

    for (genvar gi = 0; gi < NUM_TIMED; gi++) begin : g_timer
        otg_wait_timer #(.W(TMR_W)) u_timer (
            .clk     (clk),
            .rst     (rst),
            .active  (state_q == timed_state(gi)),
            .limit   (limits[gi]),
            .expired (expired[gi])
        );
    end

    otg_next_state u_next (
        .cur           (state_q),
        .st            (stat),
        .ev            (evs),
        .vrise_expired (expired[0]),
        .bcon_expired  (expired[1]),
        .nxt           (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_B_IDLE;
        else     state_q <= state_d;
    end

    otg_role_decode u_decode (
        .cur  (state_q),
        .role (role)
    );

    assign state_code  = state_q;
    assign vbus_drive  = role.vbus_drive;
    assign host_mode   = role.host;
    assign periph_mode = role.periph;
endmodule

// File: rtl/otg_role_checker.sv
module otg_role_checker (
    input logic       clk,
    input logic       rst,
    input logic       id_is_a,
    input logic       vbus_ok,
    input logic       peer_attached,
    input logic       hnp_en,
    input logic       ev_req_host,
    input logic       ev_clear_err,
    input logic [3:0] state_code,
    input logic       vbus_drive
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> state_code == 4'd0);

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
        state_code <= 4'd11);

    assert_a_auto_R3: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd0 && id_is_a) |=> state_code == 4'd4);

    assert_hnp_swap_R8: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd8 && id_is_a && vbus_ok && !peer_attached && hnp_en)
        |=> state_code == 4'd9);

    assert_no_host_without_event_R9: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd2 && !ev_req_host) |=> state_code != 4'd3);

    assert_vfall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd10 && vbus_ok) |=> state_code == 4'd10);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd11 && id_is_a && !ev_clear_err) |=> state_code == 4'd11);

    assert_no_drive_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (state_code <= 4'd4 || state_code >= 4'd10) |-> !vbus_drive);
endmodule

bind otg_role_fsm otg_role_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .id_is_a       (id_is_a),
    .vbus_ok       (vbus_ok),
    .peer_attached (peer_attached),
    .hnp_en        (hnp_en),
    .ev_req_host   (ev_req_host),
    .ev_clear_err  (ev_clear_err),
    .state_code    (state_code),
    .vbus_drive    (vbus_drive)
);

// File: tb/otg_role_fsm_bench.sv
module otg_role_fsm_bench;
    localparam int TW     = 8;
    localparam int VRISE  = 3;
    localparam int BCON   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic id_is_a = 1'b0, vbus_ok = 1'b0, peer_attached = 1'b0;
    logic bus_idle = 1'b0, hnp_en = 1'b0;
    logic ev_bus_suspend = 1'b0, ev_bus_resume = 1'b0, ev_req_host = 1'b0;
    logic ev_reclaim = 1'b0, ev_clear_err = 1'b0;
    logic [TW-1:0] vrise_limit = TW'(VRISE);
    logic [TW-1:0] bcon_limit  = TW'(BCON);
    logic [3:0] state_code;
    logic vbus_drive, host_mode, periph_mode;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    otg_role_fsm #(.TMR_W(TW)) u_otg_role_fsm (
        .clk(clk), .rst(rst), .id_is_a(id_is_a), .vbus_ok(vbus_ok),
        .peer_attached(peer_attached), .bus_idle(bus_idle), .hnp_en(hnp_en),
        .ev_bus_suspend(ev_bus_suspend), .ev_bus_resume(ev_bus_resume),
        .ev_req_host(ev_req_host), .ev_reclaim(ev_reclaim),
        .ev_clear_err(ev_clear_err), .vrise_limit(vrise_limit),
        .bcon_limit(bcon_limit), .state_code(state_code),
        .vbus_drive(vbus_drive), .host_mode(host_mode), .periph_mode(periph_mode)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {id_is_a, vbus_ok, peer_attached, bus_idle, hnp_en} = '0;
        {ev_bus_suspend, ev_bus_resume, ev_req_host, ev_reclaim, ev_clear_err} = '0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic to_a_host();
        do_reset();
        id_is_a = 1'b1;
        step(2);
        vbus_ok = 1'b1;
        step(1);
        peer_attached = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state", state_code, 0);
        chk("R1 roles", {vbus_drive, host_mode, periph_mode}, 0);
        step(1);
        chk("R1 hold idle", state_code, 0);
    endtask

    task automatic t_a_chain();
        do_reset();
        id_is_a = 1'b1;
        step(1); chk("R3 a-idle", state_code, 4);
        chk("R12 no drive a-idle", vbus_drive, 0);
        step(1); chk("R3 vrise", state_code, 5);
        chk("R12 drive vrise", vbus_drive, 1);
        vbus_ok = 1'b1;
        step(1); chk("R3 wait peer", state_code, 6);
        peer_attached = 1'b1;
        step(1); chk("R3 a-host", state_code, 7);
        chk("R13 host_mode", host_mode, 1);
        chk("R13 periph off", periph_mode, 0);
        peer_attached = 1'b0;
        step(1); chk("R3 disconnect", state_code, 6);
    endtask

    task automatic t_vrise_timeout();
        do_reset();
        id_is_a = 1'b1;
        step(2);
        chk("R4 entered", state_code, 5);
        step(VRISE);
        chk("R4 still waiting", state_code, 5);
        step(1);
        chk("R4 error", state_code, 11);
        chk("R12 no drive err", vbus_drive, 0);
        ev_bus_resume = 1'b1; step(1); ev_bus_resume = 1'b0;
        chk("R14 resume ignored in err", state_code, 11);
        step(2);
        chk("R11 err sticky", state_code, 11);
        ev_clear_err = 1'b1; step(1); ev_clear_err = 1'b0;
        chk("R11 clear to vfall", state_code, 10);
        step(1);
        chk("R10 vfall to a-idle", state_code, 4);
    endtask

    task automatic t_bcon_timeout();
        do_reset();
        id_is_a = 1'b1;
        step(2);
        vbus_ok = 1'b1;
        step(1);
        chk("R5 entered", state_code, 6);
        step(BCON);
        chk("R5 still waiting", state_code, 6);
        step(1);
        chk("R5 vfall", state_code, 10);
    endtask

    task automatic t_suspend();
        to_a_host();
        ev_bus_resume = 1'b1; step(1); ev_bus_resume = 1'b0;
        chk("R14 resume ignored in host", state_code, 7);
        ev_bus_suspend = 1'b1; step(1); ev_bus_suspend = 1'b0;
        chk("R7 suspend", state_code, 8);
        chk("R12 drive suspend", vbus_drive, 1);
        ev_bus_resume = 1'b1; step(1); ev_bus_resume = 1'b0;
        chk("R7 resume", state_code, 7);
        ev_bus_suspend = 1'b1; step(1); ev_bus_suspend = 1'b0;
        hnp_en = 1'b1; peer_attached = 1'b0;
        step(1);
        chk("R8 hnp swap", state_code, 9);
        chk("R13 periph a", periph_mode, 1);
        chk("R12 drive a-periph", vbus_drive, 1);
        ev_reclaim = 1'b1; step(1); ev_reclaim = 1'b0;
        chk("R8 reclaim", state_code, 6);
        to_a_host();
        ev_bus_suspend = 1'b1; step(1); ev_bus_suspend = 1'b0;
        peer_attached = 1'b0;
        step(1);
        chk("R8 no hnp", state_code, 6);
    endtask

    task automatic t_vbus_loss();
        to_a_host();
        vbus_ok = 1'b0;
        step(1);
        chk("R11 host vbus loss", state_code, 11);
        id_is_a = 1'b0;
        step(1);
        chk("R11 id leaves err", state_code, 10);
        step(1);
        chk("R10 vfall to b-idle", state_code, 0);
    endtask

    task automatic t_id_change();
        to_a_host();
        id_is_a = 1'b0;
        step(1);
        chk("R10 to vfall", state_code, 10);
        chk("R12 no drive vfall", vbus_drive, 0);
        step(3);
        chk("R10 hold with vbus", state_code, 10);
        vbus_ok = 1'b0;
        step(1);
        chk("R10 b-idle", state_code, 0);
    endtask

    task automatic t_b_side();
        do_reset();
        step(2);
        chk("R6 idle without vbus", state_code, 0);
        vbus_ok = 1'b1;
        step(1); chk("R6 wait peer", state_code, 1);
        peer_attached = 1'b1;
        step(1); chk("R6 b-periph", state_code, 2);
        chk("R13 periph b", periph_mode, 1);
        chk("R12 no drive b", vbus_drive, 0);
        bus_idle = 1'b1;
        ev_req_host = 1'b1; step(1); ev_req_host = 1'b0;
        chk("R14 req_host without hnp", state_code, 2);
        ev_reclaim = 1'b1; step(1); ev_reclaim = 1'b0;
        chk("R14 reclaim ignored b", state_code, 2);
        hnp_en = 1'b1; bus_idle = 1'b0;
        ev_req_host = 1'b1; step(1); ev_req_host = 1'b0;
        chk("R9 needs bus idle", state_code, 2);
        bus_idle = 1'b1;
        ev_req_host = 1'b1; step(1); ev_req_host = 1'b0;
        chk("R9 b-host", state_code, 3);
        chk("R13 host b", host_mode, 1);
        peer_attached = 1'b0;
        step(1); chk("R9 back to periph", state_code, 2);
        vbus_ok = 1'b0;
        step(1); chk("R6 vbus loss", state_code, 0);
        chk("R2 idle code", state_code, 0);
    endtask

    initial begin
        step(1);
        t_reset();
        t_a_chain();
        t_vrise_timeout();
        t_bcon_timeout();
        t_suspend();
        t_vbus_loss();
        t_id_change();
        t_b_side();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule